// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block watches a processor's event pulses and counts them in two independent 32-bit counters. Each counter picks one of sixteen event inputs. Counting is allowed only in the privilege modes that software has enabled in a shared control word. A single level-sensitive interrupt request tells software that a counter's top bit is set. To get an interrupt every N events, software loads a counter with 0x80000000 minus N. The interrupt handler then loads a fresh preset, which clears the request.

Software reaches the unit through a plain register port. Address 0 selects the control word and address 1 selects the packed count word. Writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `perf_event_counter_unit`

## Requirements
- R1: After reset the control word reads 0, both counters read 0 and irq is low.
- R2: A write to address 0 stores wdata bits 12:0 as the control word. Reading address 0 returns those 13 bits, and bits 63:13 read as zero.
- R3: A write to address 1 loads counter A from bits 31:0 and counter B from bits 63:32. Reading address 1 returns {B, A}.
- R4: Counter A follows event_in at the index held in control bits 8:5, and counter B follows the index in bits 12:9. Each counter adds exactly one on every cycle in which its selected input is high and the mode is qualified.
- R5: Mode qualification works as follows. When exc_level is 1, only control bit 0 decides. Otherwise priv_mode 0 (kernel) uses bit 1, priv_mode 1 (supervisor) uses bit 2, priv_mode 2 (user) uses bit 3, and priv_mode 3 never counts.
- R6: A count-register write in the same cycle as a qualified event loads the written value exactly, and that cycle's event is not added.
- R7: A counter preset to 0x80000000 minus N has bit 31 clear after N-1 qualified events and set after N.
- R8: irq is high exactly when control bit 4 is 1 and either counter has bit 31 set. It falls when the count is rewritten with both bit 31s clear, or when bit 4 is cleared.
- R9: Counting continues past bit 31 and wraps modulo 2^32. A counter at 0xFFFFFFFF goes to 0 on the next event, and its bit 31 then no longer holds irq.
- R10: With an all-zero control word, neither counter changes whatever the event and mode inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects packed count |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the addressed register |
| event_in | input | 16 | Event pulse inputs |
| priv_mode | input | 2 | Current base privilege mode |
| exc_level | input | 1 | Processor is at exception level |
| irq | output | 1 | Overflow interrupt request (level) |

## Verification
The checker watches every cycle. It checks that counters only hold, step by one or load a written value, that register writes land one edge later, and that a disabled mode or exception-level gate freezes a counter. It also checks that irq is never high without interrupt enable and a set top bit. The bench's sweeps are needed for the rest. They show which of the sixteen inputs each selector really picks, the full truth table of the mode and exception-level qualifier, the exact event count at which bit 31 rises under a preset, and the wrap from all-ones to zero.

// File: rtl/perf_event_pkg.sv
package perf_event_pkg;
   localparam int CTRL_W      = 13;
   localparam int BIT_EXC     = 0;
   localparam int BIT_KERNEL  = 1;
   localparam int BIT_SUPER   = 2;
   localparam int BIT_USER    = 3;
   localparam int BIT_IRQ_EN  = 4;
   localparam int SEL_LSB     = 5;

   typedef enum logic [1:0] {
      PRIV_KERNEL = 2'd0,
      PRIV_SUPER  = 2'd1,
      PRIV_USER   = 2'd2,
      PRIV_NONE   = 2'd3
   } priv_e;

   localparam logic ADDR_CTRL  = 1'b0;
   localparam logic ADDR_COUNT = 1'b1;
endpackage

// File: rtl/perf_mode_qual.sv
module perf_mode_qual
   import perf_event_pkg::*;
(
   input  logic [3:0] mode_en,
   input  logic       exc_level,
   input  logic [1:0] priv_mode,
   output logic       allow
);
   priv_e pm;
   always_comb begin
      pm = priv_e'(priv_mode);
      if (exc_level) begin
         allow = mode_en[BIT_EXC];
      end else begin
         unique case (pm)
            PRIV_KERNEL: allow = mode_en[BIT_KERNEL];
            PRIV_SUPER:  allow = mode_en[BIT_SUPER];
            PRIV_USER:   allow = mode_en[BIT_USER];
            default:     allow = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/perf_event_lane.sv
module perf_event_lane #(
   parameter int CNT_W  = 32,
   parameter int NUM_EV = 16,
   localparam int SEL_W = $clog2(NUM_EV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              allow,
   input  logic [SEL_W-1:0]  sel,
   input  logic [NUM_EV-1:0] events,
   input  logic              ld_en,
   input  logic [CNT_W-1:0]  ld_val,
   output logic [CNT_W-1:0]  cnt
);
   logic hit;
   assign hit = allow & events[sel];

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (ld_en)  cnt <= ld_val;
      else if (hit)    cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/perf_event_counter_unit.sv
module perf_event_counter_unit
   import perf_event_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int NUM_EV  = 16,
   parameter int NUM_CNT = 2,
   localparam int SEL_W  = $clog2(NUM_EV),
   localparam int DATA_W = CNT_W * NUM_CNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic [NUM_EV-1:0] event_in,
   input  logic [1:0]        priv_mode,
   input  logic              exc_level,
   output logic              irq
);
   generate
      if (DATA_W != 64)
         $error("packed count word must be 64 bits wide");
      if (SEL_LSB + NUM_CNT * SEL_W != CTRL_W)
         $error("selector fields must fill control bits up to CTRL_W");
      if (NUM_EV != (1 << SEL_W))
         $error("NUM_EV must be a power of two");
   endgenerate

   logic [CTRL_W-1:0]             ctrl_q;
   logic [NUM_CNT-1:0][CNT_W-1:0] lane_cnt;
   logic [NUM_CNT-1:0]            lane_msb;
   logic                          allow;
   logic                          wr_ctrl, wr_count;

   assign wr_ctrl  = reg_wr_en && (reg_addr == ADDR_CTRL);
   assign wr_count = reg_wr_en && (reg_addr == ADDR_COUNT);

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
   end

   perf_mode_qual mode_i (
      .mode_en   (ctrl_q[BIT_USER:BIT_EXC]),
      .exc_level (exc_level),
      .priv_mode (priv_mode),
      .allow     (allow)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
      perf_event_lane #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) lane_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .allow  (allow),
         .sel    (ctrl_q[SEL_LSB + i*SEL_W +: SEL_W]),
         .events (event_in),
         .ld_en  (wr_count),
         .ld_val (reg_wdata[i*CNT_W +: CNT_W]),
         .cnt    (lane_cnt[i])
      );
      assign lane_msb[i] = lane_cnt[i][CNT_W-1];
   end

   assign irq = ctrl_q[BIT_IRQ_EN] & (|lane_msb);

   always_comb begin
      if (reg_addr == ADDR_COUNT) reg_rdata = lane_cnt;
      else                        reg_rdata = {{(64-CTRL_W){1'b0}}, ctrl_q};
   end
endmodule

// File: rtl/perf_event_counter_unit_chk.sv
module perf_event_counter_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr_en,
   input logic        reg_addr,
   input logic [63:0] reg_wdata,
   input logic [1:0]  priv_mode,
   input logic        exc_level,
   input logic [12:0] ctrl,
   input logic [31:0] cnt_a,
   input logic [31:0] cnt_b,
   input logic        irq
);
   logic wr_cnt, wr_ctl;
   assign wr_cnt = reg_wr_en && reg_addr;
   assign wr_ctl = reg_wr_en && !reg_addr;

   p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> ctrl == $past(reg_wdata[12:0]));
   p_count_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> {cnt_b, cnt_a} == $past(reg_wdata));
   p_step_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 32'd1));
   p_step_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) + 32'd1));
   p_exc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_level && !ctrl[0] && !wr_cnt) |=> ($stable(cnt_a) && $stable(cnt_b)));
   p_user_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_level && priv_mode == 2'd2 && !ctrl[3] && !wr_cnt) |=> $stable(cnt_a));
   p_irq_needs_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt_a[31] || cnt_b[31]));
   p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[4] |-> !irq);
   p_zero_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl == 13'd0 && !wr_cnt) |=> ($stable(cnt_a) && $stable(cnt_b)));
endmodule

bind perf_event_counter_unit perf_event_counter_unit_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .priv_mode (priv_mode),
   .exc_level (exc_level),
   .ctrl      (ctrl_q),
   .cnt_a     (lane_cnt[0]),
   .cnt_b     (lane_cnt[1]),
   .irq       (irq)
);

// File: tb/perf_event_counter_unit_tb_top.sv
`timescale 1ns/1ps
module perf_event_counter_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic        reg_addr = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [15:0] event_in = '0;
   logic [1:0]  priv_mode = 2'd0;
   logic        exc_level = 1'b0;
   logic        irq;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   perf_event_counter_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in),
      .priv_mode(priv_mode), .exc_level(exc_level), .irq(irq)
   );

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(logic a, logic [63:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(logic a, output logic [63:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic pulse(logic [15:0] ev, int n);
      @(negedge clk);
      event_in = ev;
      repeat (n) @(posedge clk);
      @(negedge clk);
      event_in = '0;
   endtask

   function automatic logic [63:0] mk_ctrl(int sa, int sb, logic ie, logic [3:0] m);
      return 64'((sb << 9) | (sa << 5) | (int'(ie) << 4) | int'(m));
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      rd(1'b0, d); check("R1 ctrl", d, 64'd0);
      rd(1'b1, d); check("R1 count", d, 64'd0);
      check("R1 irq", 64'(irq), 64'd0);

      // R2: control write, upper bits read zero
      wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(1'b0, d); check("R2 ctrl mask", d, 64'h1FFF);
      wr(1'b0, 64'h0000_0000_0000_0A5A);
      rd(1'b0, d); check("R2 ctrl value", d, 64'h0A5A);

      // R3: packed count write/read
      wr(1'b0, 64'd0);
      wr(1'b1, 64'h1234_5678_0BAD_F00D);
      rd(1'b1, d); check("R3 packing", d, 64'h1234_5678_0BAD_F00D);

      // R4: selector sweep for both lanes
      for (int s = 0; s < 16; s++) begin
         wr(1'b0, mk_ctrl(s, 15 - s, 1'b0, 4'b0010));
         wr(1'b1, 64'd0);
         pulse(16'(1 << s), 3);
         rd(1'b1, d); check($sformatf("R4 sel A=%0d", s), d, 64'd3);
         pulse(16'(1 << (15 - s)), 2);
         rd(1'b1, d); check($sformatf("R4 sel B=%0d", 15 - s), d, {32'd2, 32'd3});
      end

      // R5: mode qualifier truth table
      for (int e = 0; e < 2; e++) begin
         for (int pm = 0; pm < 4; pm++) begin
            for (int mb = 0; mb < 16; mb++) begin
               int exp_n;
               if (e == 1)       exp_n = mb & 1;
               else if (pm == 3) exp_n = 0;
               else              exp_n = (mb >> (pm + 1)) & 1;
               exp_n = exp_n * 3;
               wr(1'b0, mk_ctrl(2, 7, 1'b0, 4'(mb)));
               wr(1'b1, 64'd0);
               exc_level = e[0]; priv_mode = 2'(pm);
               pulse(16'hFFFF, 3);
               rd(1'b1, d);
               check($sformatf("R5 exc=%0d pm=%0d mb=%0h", e, pm, mb), d,
                     {32'(exp_n), 32'(exp_n)});
            end
         end
      end
      exc_level = 1'b0; priv_mode = 2'd0;

      // R6: write beats simultaneous event
      wr(1'b0, mk_ctrl(0, 1, 1'b0, 4'b0010));
      @(negedge clk);
      event_in = 16'hFFFF;
      reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wdata = 64'h0000_0009_0000_0005;
      @(negedge clk);
      reg_wr_en = 1'b0; event_in = '0;
      rd(1'b1, d); check("R6 write precedence", d, 64'h0000_0009_0000_0005);

      // R7/R8: overflow at preset N and interrupt
      wr(1'b0, mk_ctrl(0, 1, 1'b1, 4'b0010));
      wr(1'b1, {32'd0, 32'h8000_0000 - 32'd4});
      pulse(16'h0001, 3);
      rd(1'b1, d); check("R7 before N", d, {32'd0, 32'h7FFF_FFFF});
      check("R8 irq low before", 64'(irq), 64'd0);
      pulse(16'h0001, 1);
      rd(1'b1, d); check("R7 at N", d, {32'd0, 32'h8000_0000});
      check("R8 irq high", 64'(irq), 64'd1);
      wr(1'b0, mk_ctrl(0, 1, 1'b0, 4'b0010));
      check("R8 irq off by enable", 64'(irq), 64'd0);
      wr(1'b0, mk_ctrl(0, 1, 1'b1, 4'b0010));
      check("R8 irq back", 64'(irq), 64'd1);
      wr(1'b1, {32'h8000_0001, 32'd7});
      check("R8 irq via counter B", 64'(irq), 64'd1);
      wr(1'b1, {32'd1, 32'd7});
      check("R8 irq cleared by rewrite", 64'(irq), 64'd0);

      // R9: wrap
      wr(1'b1, {32'hFFFF_FFFF, 32'd0});
      check("R9 irq before wrap", 64'(irq), 64'd1);
      pulse(16'h0002, 1);
      rd(1'b1, d); check("R9 wrap value", d, 64'd0);
      check("R9 irq after wrap", 64'(irq), 64'd0);

      // R10: zero control stops everything
      wr(1'b0, 64'd0);
      wr(1'b1, {32'd11, 32'd22});
      for (int e = 0; e < 2; e++) begin
         for (int pm = 0; pm < 4; pm++) begin
            exc_level = e[0]; priv_mode = 2'(pm);
            pulse(16'hFFFF, 2);
         end
      end
      rd(1'b1, d); check("R10 frozen", d, {32'd11, 32'd22});
      check("R10 irq", 64'(irq), 64'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule